// File: doc/BRIEF.md
# Three-Channel Complementary Compare PWM with Dead-Band

This block turns one shared timer count into six PWM pins. Three compare channels watch the same count, each against its own compare value. Each channel holds a pending compare value that software may rewrite at any time, and a working value that is used for matching. The pending value becomes the working value only on the timer's reload strobe, so a pulse width can change mid-run without a glitch.

Each channel drives one complementary pin pair. When the channel's compare state changes, a dead-band stage holds the pin that is turning on back by a programmable number of clock ticks. The pin that is turning off drops at once, so the two pins of a pair are never on together. A per-pin action code then sets the polarity of each pin or forces it to a level. A global enable drives one output-enable signal, which stands for the pins going to high impedance.

The timer itself is outside the block. Its count, its direction and its reload strobe arrive as inputs.

Top module: `cmp_pwm_trio`

## Requirements
- R1: While reset is asserted and just after it is released, every pin reads 0 and `pwm_oe` is 0. After reset, all action codes are 00, the dead-band is 0, and all compare values are 0.
- R2: A write with `wr_en` high takes effect at the next clock edge, and the address selects the target:
  - addresses 0, 1 and 2 load the pending compare value of channel 0, 1 or 2;
  - address 3 loads the action codes from data bits [11:0], with bits [2k+1:2k] belonging to pin k;
  - address 4 loads the dead-band length from bits [7:0];
  - address 5 loads the enable from bit 0.
- R3: On a clock edge where `tmr_reload` is high, each working compare value takes the pending value held before that edge. A pending write in the same cycle affects only the next reload. Without a reload, the working value never changes.
- R4: A channel's compare state is cleared at the edge where `tmr_reload` is high, and the reload wins over a match. Otherwise, when `tmr_cnt` equals the working value, the state becomes `tmr_up` (1 when counting up, 0 when counting down). With no reload and no match, the state holds.
- R5: Channel u owns pins 2u and 2u+1. Pin 2u's logical level is the compare state, and pin 2u+1's logical level is its complement. Both are formed before dead-band insertion.
- R6: In the first cycle a channel's compare state differs from the previous cycle, both logical levels of that pair go to 0. They stay at 0 for exactly D cycles in total, where D is the dead-band length. The pin whose level falls goes to 0 in that first cycle.
- R7: If the compare state changes again while a dead-band interval is running, the interval restarts with a full length D, and both levels stay 0 throughout.
- R8: With D = 0, logical levels follow the compare state in the same cycle it changes, with no gap.
- R9: The action code of each pin maps the logical level to the pin as follows: 00 drives 0, 01 drives the inverted level, 10 drives the level, and 11 drives 1.
- R10: `pwm_oe` equals the enable bit, and it follows a write to address 5 at the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Timer clock |
| rst_n | input | 1 | Active-low reset |
| tmr_cnt | input | 16 | Shared timer count |
| tmr_up | input | 1 | Timer direction, 1 = counting up |
| tmr_reload | input | 1 | Reload strobe, high in the cycle the count is zero |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 16 | Register write data |
| pwm_out | output | 6 | Pin levels, pin 2u and 2u+1 belong to channel u |
| pwm_oe | output | 1 | Output enable; 0 models high-impedance pins |

## Verification
Two pairs of events can land on the same edge:
- a write to a pending compare value and the reload strobe;
- a compare-state change and a dead-band interval that is still running.

The bench provokes the first pair by issuing a compare write exactly in the zero-count cycle. It then judges the result by where later pin edges fall.

For the second pair, a compare value is placed one step below the timer's turning point. The up match and the down match then arrive two cycles apart under a longer dead-band.

Both cases, and thousands of random cycles with random writes, are compared cycle by cycle against a bench model. The model counts the remaining quiet cycles of each pair in its own way.

// File: rtl/cpt_pkg.sv
package cpt_pkg;

  typedef enum logic [1:0] {
    PIN_FORCE_LO = 2'b00,
    PIN_INVERTED = 2'b01,
    PIN_TRUE     = 2'b10,
    PIN_FORCE_HI = 2'b11
  } pin_act_e;

  localparam int unsigned ADDR_ACTIONS  = 3;
  localparam int unsigned ADDR_DEADBAND = 4;
  localparam int unsigned ADDR_ENABLE   = 5;

  function automatic logic drive_pin(input pin_act_e act, input logic lvl);
    logic r;
    case (act)
      PIN_FORCE_LO: r = 1'b0;
      PIN_INVERTED: r = ~lvl;
      PIN_TRUE:     r = lvl;
      default:      r = 1'b1;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/cpt_cmp_unit.sv
module cpt_cmp_unit #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] cnt,
  input  logic          dir_up,
  input  logic          reload,
  input  logic          sh_we,
  input  logic [CW-1:0] sh_wd,
  output logic          state,
  output logic          hit
);

  logic [CW-1:0] pend_q;
  logic [CW-1:0] work_q;
  logic          st_q;

  assign hit   = (cnt == work_q);
  assign state = st_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      work_q <= '0;
      st_q   <= 1'b0;
    end else begin
      if (sh_we)  pend_q <= sh_wd;
      if (reload) work_q <= pend_q;
      if (reload)   st_q <= 1'b0;
      else if (hit) st_q <= dir_up;
    end
  end

  AST_WORK_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !reload |=> $stable(work_q)); // R3
  AST_RELOAD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    reload |=> !st_q); // R4
  AST_UP_MATCH_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (!reload && hit && dir_up) |=> st_q); // R4
  AST_DOWN_MATCH_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (!reload && hit && !dir_up) |=> !st_q); // R4
  AST_STATE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!reload && !hit) |=> $stable(st_q)); // R4

endmodule

// File: rtl/cpt_deadband.sv
module cpt_deadband #(
  parameter int DBW = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           state,
  input  logic [DBW-1:0] db_len,
  output logic           lvl_a,
  output logic           lvl_b,
  output logic           quiet
);

  logic           prev_q;
  logic [DBW-1:0] hold_q;
  logic           flip;

  function automatic logic [DBW-1:0] gap_load(input logic [DBW-1:0] d);
    return (d == '0) ? '0 : d - DBW'(1);
  endfunction

  assign flip  = state ^ prev_q;
  assign quiet = flip ? (db_len != '0) : (hold_q != '0);
  assign lvl_a = state & ~quiet;
  assign lvl_b = ~state & ~quiet;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      hold_q <= '0;
    end else begin
      prev_q <= state;
      if (flip)               hold_q <= gap_load(db_len);
      else if (hold_q != '0)  hold_q <= hold_q - DBW'(1);
    end
  end

  AST_A_ON_DELAYED: assert property (@(posedge clk) disable iff (!rst_n)
    ((db_len != '0) && $rose(lvl_a)) |-> $past(state)); // R6
  AST_B_ON_DELAYED: assert property (@(posedge clk) disable iff (!rst_n)
    ((db_len != '0) && $rose(lvl_b)) |-> !$past(state)); // R6
  AST_A_OFF_AT_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(state) |-> !lvl_a); // R6
  AST_B_OFF_AT_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(state) |-> !lvl_b); // R6
  AST_ZERO_DB_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    ((db_len == '0) && (hold_q == '0)) |-> (lvl_a == state)); // R8

endmodule

// File: rtl/cpt_pin_map.sv
module cpt_pin_map
  import cpt_pkg::*;
#(
  parameter int NOUT = 6
) (
  input  logic [NOUT-1:0]   lvl,
  input  logic [2*NOUT-1:0] act,
  output logic [NOUT-1:0]   pins
);

  for (genvar k = 0; k < NOUT; k++) begin : g_pin
    always_comb pins[k] = drive_pin(pin_act_e'(act[2*k +: 2]), lvl[k]);
  end

endmodule

// File: rtl/cmp_pwm_trio.sv
module cmp_pwm_trio
  import cpt_pkg::*;
#(
  parameter int CW  = 16,
  parameter int DBW = 8,
  parameter int NU  = 3,
  parameter int AW  = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [CW-1:0]   tmr_cnt,
  input  logic            tmr_up,
  input  logic            tmr_reload,
  input  logic            wr_en,
  input  logic [AW-1:0]   wr_addr,
  input  logic [CW-1:0]   wr_data,
  output logic [2*NU-1:0] pwm_out,
  output logic            pwm_oe
);

  localparam int NOUT = 2 * NU;

  logic [2*NOUT-1:0] act_q;
  logic [DBW-1:0]    db_q;
  logic              en_q;
  logic [NU-1:0]     unit_state;
  logic [NU-1:0]     unit_hit;
  logic [NU-1:0]     pair_quiet;
  logic [NOUT-1:0]   pair_lvl;

  wire wr_act = wr_en && (wr_addr == AW'(ADDR_ACTIONS));
  wire wr_db  = wr_en && (wr_addr == AW'(ADDR_DEADBAND));
  wire wr_ena = wr_en && (wr_addr == AW'(ADDR_ENABLE));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= '0;
      db_q  <= '0;
      en_q  <= 1'b0;
    end else begin
      if (wr_act) act_q <= wr_data[2*NOUT-1:0];
      if (wr_db)  db_q  <= wr_data[DBW-1:0];
      if (wr_ena) en_q  <= wr_data[0];
    end
  end

  for (genvar u = 0; u < NU; u++) begin : g_unit
    cpt_cmp_unit #(.CW(CW)) u_cmp (
      .clk    (clk),
      .rst_n  (rst_n),
      .cnt    (tmr_cnt),
      .dir_up (tmr_up),
      .reload (tmr_reload),
      .sh_we  (wr_en && (wr_addr == AW'(u))),
      .sh_wd  (wr_data),
      .state  (unit_state[u]),
      .hit    (unit_hit[u])
    );
    cpt_deadband #(.DBW(DBW)) u_db (
      .clk    (clk),
      .rst_n  (rst_n),
      .state  (unit_state[u]),
      .db_len (db_q),
      .lvl_a  (pair_lvl[2*u]),
      .lvl_b  (pair_lvl[2*u+1]),
      .quiet  (pair_quiet[u])
    );
  end

  cpt_pin_map #(.NOUT(NOUT)) u_map (
    .lvl  (pair_lvl),
    .act  (act_q),
    .pins (pwm_out)
  );

  assign pwm_oe = en_q;

  AST_DISABLE_TRISTATES: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ena && !wr_data[0]) |=> !pwm_oe); // R10
  AST_ENABLE_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ena && wr_data[0]) |=> pwm_oe); // R10
  AST_RELOAD_NO_SET: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_reload |=> (unit_state == '0)); // R4
  AST_QUIET_PAIR_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (pair_quiet[0]) |-> (pair_lvl[1:0] == 2'b00)); // R6

endmodule

// File: tb/cmp_pwm_trio_tb.sv
module cmp_pwm_trio_tb;

  localparam int PER = 12;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] tmr_cnt = '0;
  logic        tmr_up = 1'b1;
  logic        tmr_reload = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [5:0]  pwm_out;
  logic        pwm_oe;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // bench model state
  logic [15:0] m_pend [3];
  logic [15:0] m_work [3];
  logic        m_st   [3];
  int          m_off  [3];
  logic [11:0] m_codes;
  int          m_db;
  logic        m_en;

  // bench timer
  int  tc = 0;
  bit  tdir = 1;

  always #5 clk = ~clk;

  cmp_pwm_trio u_dut (
    .clk(clk), .rst_n(rst_n), .tmr_cnt(tmr_cnt), .tmr_up(tmr_up),
    .tmr_reload(tmr_reload), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .pwm_out(pwm_out), .pwm_oe(pwm_oe)
  );

  function automatic logic pin_of(input logic [1:0] code, input logic v);
    return (code[1] & code[0]) | (code[1] & ~code[0] & v) | (~code[1] & code[0] & ~v);
  endfunction

  function automatic logic [5:0] model_pins();
    logic [5:0] p;
    for (int u = 0; u < 3; u++) begin
      logic calm;
      calm = (m_off[u] == 0);
      p[2*u]   = pin_of(m_codes[4*u +: 2],   m_st[u] & calm);
      p[2*u+1] = pin_of(m_codes[4*u+2 +: 2], ~m_st[u] & calm);
    end
    return p;
  endfunction

  task automatic compare_now(input string tag);
    logic [5:0] e;
    e = model_pins();
    checks++;
    if (pwm_out !== e || pwm_oe !== m_en) begin
      errors++;
      $display("FAIL %s at %0t: out=%b oe=%b expected out=%b oe=%b",
               tag, $time, pwm_out, pwm_oe, e, m_en);
    end
  endtask

  // one clock: timer advances, optional write; model follows; then check
  task automatic step(input bit we, input int wa, input logic [15:0] wd,
                      input string tag);
    logic        st_old [3];
    logic [15:0] cnt_i;
    bit          up_i, rl_i;
    cnt_i = 16'(tc);
    up_i  = tdir;
    rl_i  = (tc == 0);
    tmr_cnt = cnt_i; tmr_up = up_i; tmr_reload = rl_i;
    wr_en = we; wr_addr = 3'(wa); wr_data = wd;
    @(posedge clk);
    for (int u = 0; u < 3; u++) begin
      logic [15:0] w_old;
      st_old[u] = m_st[u];
      w_old = m_work[u];
      if (rl_i) m_work[u] = m_pend[u];
      if (rl_i) m_st[u] = 1'b0;
      else if (cnt_i == w_old) m_st[u] = up_i;
      if (we && wa == u) m_pend[u] = wd;
    end
    if (we && wa == 3) m_codes = wd[11:0];
    if (we && wa == 4) m_db = int'(wd[7:0]);
    if (we && wa == 5) m_en = wd[0];
    for (int u = 0; u < 3; u++) begin
      if (m_st[u] != st_old[u]) m_off[u] = m_db;
      else if (m_off[u] > 0) m_off[u]--;
    end
    if (tdir) begin
      tc++;
      if (tc == PER) tdir = 0;
    end else begin
      tc--;
      if (tc == 0) tdir = 1;
    end
    @(negedge clk);
    wr_en = 1'b0;
    compare_now(tag);
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) step(1'b0, 0, 16'h0, tag);
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7151));
    for (int u = 0; u < 3; u++) begin
      m_pend[u] = '0; m_work[u] = '0; m_st[u] = 1'b0; m_off[u] = 0;
    end
    m_codes = '0; m_db = 0; m_en = 1'b0;

    // R1: reset state
    repeat (3) @(negedge clk);
    compare_now("R1");
    rst_n = 1'b1;
    @(negedge clk);
    compare_now("R1");

    // R2 / R10: configuration writes, enable drives the output enable
    step(1'b1, 5, 16'h0001, "R10");
    step(1'b1, 3, 16'b0110_0110_0110, "R2");
    step(1'b1, 0, 16'd4, "R2");
    step(1'b1, 1, 16'd7, "R2");
    step(1'b1, 2, 16'd10, "R2");
    step(1'b1, 4, 16'd3, "R6");
    idle(4 * PER, "R5");
    idle(2 * PER, "R6");

    // R9: forced and inverted actions
    step(1'b1, 3, 16'hFFF, "R9");
    idle(PER, "R9");
    step(1'b1, 3, 16'h000, "R9");
    idle(PER, "R9");
    step(1'b1, 3, 16'b0101_1001_0110, "R9");
    idle(2 * PER, "R9");

    // R3: compare write lands in the same cycle as the reload
    while (tc != 0) step(1'b0, 0, 16'h0, "R3");
    step(1'b1, 0, 16'd2, "R3");
    idle(2 * PER, "R3");
    idle(2 * PER, "R4");

    // R7: up and down matches two cycles apart under a long dead-band
    step(1'b1, 1, 16'(PER - 1), "R7");
    step(1'b1, 4, 16'd5, "R7");
    idle(6 * PER, "R7");

    // R8: zero dead-band passes edges at once
    step(1'b1, 4, 16'd0, "R8");
    idle(4 * PER, "R8");

    // R10: disable
    step(1'b1, 5, 16'h0000, "R10");
    idle(4, "R10");
    step(1'b1, 5, 16'h0001, "R10");

    // random mix
    for (int i = 0; i < 4000; i++) begin
      if (($urandom % 12) == 0) begin
        int a;
        logic [15:0] d;
        a = int'($urandom % 6);
        case (a)
          0, 1, 2: d = 16'($urandom % (PER + 2));
          3:       d = 16'($urandom);
          4:       d = 16'($urandom % 6);
          default: d = 16'(($urandom % 5) != 0);
        endcase
        step(1'b1, a, d, "R6/R7/R4");
      end else begin
        step(1'b0, 0, 16'h0, "R5");
      end
    end

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule